// File: doc/BRIEF.md
# Floating-Point Exception Control and Trap Decision

This block holds the 64-bit floating-point control and status word of a processor core. It also decides what happens when a floating-point or integer-convert operation completes with exception conditions. Software writes the whole word in one cycle and reads it back at any time.

Each completing operation presents a valid strobe and six condition bits. The block folds those bits into sticky status flags. It supplies the rounding mode to use, taking it from the word whenever the instruction asks for dynamic rounding. It then decides, for each condition, whether to request a trap or to suppress the trap and have the datapath substitute a result. The substitute is either the IEEE non-trapping result or, for underflow, a forced +0.0.

The block computes no arithmetic result and does not handle the trap. It only emits a trap request, a cause vector and two substitution selects.

Top module: `fpx_ctl`

## Requirements
- R1: After reset, every bit of `sw_rdata` is 0 and `trap_req`, `trap_cause`, `sub_ieee` and `sub_zero` are 0.
- R2: A write (`sw_we`=1) stores `sw_wdata` bits 61:49 and is visible on `sw_rdata` from the next cycle. All other bits read 0 and ignore writes. The control fields are: bit 61 underflow-disable, bit 60 underflow-to-zero, bits 59:58 dynamic rounding code, bit 51 overflow-disable, bit 50 divide-by-zero-disable, bit 49 invalid-disable.
- R3: Condition bit k of `cmp_exc` maps to status flag bit 52+k. The order is k=0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 integer overflow. A flag is set on a cycle with `cmp_vld`=1 and its condition bit 1, and it then holds until a software write.
- R4: When a software write and a hardware flag set fall in the same cycle, the flag ends up set.
- R5: `rm_eff` equals the word's bits 59:58 when `cmp_rm_dyn`=1 and equals `cmp_rm_static` otherwise. The code is 00 chopped, 01 toward minus infinity, 10 to nearest, 11 toward plus infinity.
- R6: Underflow traps when the underflow-disable bit is 0. It also traps when underflow-disable is 1 and underflow-to-zero is 0. When both are 1, it does not trap and `sub_zero` is 1.
- R7: Overflow and divide-by-zero each trap unless their disable bit is 1. In that case there is no trap and `sub_ieee` is 1.
- R8: Invalid suppresses its trap and sets `sub_ieee` only when invalid-disable is 1 and `cmp_inv_fixable` is 1. Otherwise it traps.
- R9: Inexact never traps and never sets its cause bit. Integer overflow always traps.
- R10: `trap_cause` bit k (same order as R3) is 1 when condition k traps, and `trap_req` is the OR of `trap_cause`.
- R11: Decisions use the control bits stored before the current cycle's write. With TRAP_REG=1 the trap and substitution outputs appear one cycle after the completion.
- R12: With `cmp_vld`=0, the condition inputs have no effect on the flags or the trap and substitution outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | XLEN | Software write data |
| sw_rdata | output | XLEN | Current register word |
| cmp_vld | input | 1 | An operation completes this cycle |
| cmp_exc | input | 6 | Condition bits of the completing operation |
| cmp_inv_fixable | input | 1 | Hardware can produce the correct invalid result |
| cmp_rm_dyn | input | 1 | Instruction requests dynamic rounding |
| cmp_rm_static | input | 2 | Rounding code encoded in the instruction |
| rm_eff | output | 2 | Rounding code to apply |
| trap_req | output | 1 | Trap request |
| trap_cause | output | 6 | Conditions that trapped |
| sub_ieee | output | 1 | Substitute the IEEE non-trapping result |
| sub_zero | output | 1 | Force the destination to +0.0 |

## Verification
The bench builds the block with XLEN=64, TRAP_REG=1 and HW_SET_WINS=1. The full 64-bit width puts the zero padding above bit 61 and below bit 49 on the read port, where it can be checked. The registered decision outputs make a write and a completion in the same cycle distinguishable: a trap that follows the old control bits is visible one cycle later, next to the new stored word. The hardware-wins setting is the one the sticky-flag collision test relies on.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int EXC_N       = 6;
   localparam int EXC_INV     = 0;
   localparam int EXC_DZE     = 1;
   localparam int EXC_OVF     = 2;
   localparam int EXC_UNF     = 3;
   localparam int EXC_INE     = 4;
   localparam int EXC_IOV     = 5;
   localparam int POS_LO      = 49;
   localparam int POS_INV_DIS = 49;
   localparam int POS_DZ_DIS  = 50;
   localparam int POS_OVF_DIS = 51;
   localparam int POS_FLAG_LO = 52;
   localparam int POS_RM_LO   = 58;
   localparam int POS_UF_ZERO = 60;
   localparam int POS_UF_DIS  = 61;
   localparam int POS_HI      = 61;

   typedef enum logic [1:0] {
      RM_CHOP = 2'b00,
      RM_MINF = 2'b01,
      RM_NEAR = 2'b10,
      RM_PINF = 2'b11
   } rmode_e;

   typedef struct packed {
      logic   uf_dis;
      logic   uf_zero;
      rmode_e rm;
      logic   ovf_dis;
      logic   dz_dis;
      logic   inv_dis;
   } ctl_t;
endpackage

// File: rtl/fpx_csr.sv
module fpx_csr
   import fpx_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter bit HW_SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [XLEN-1:0]  sw_wdata,
   input  logic             set_vld,
   input  logic [EXC_N-1:0] set_exc,
   output ctl_t             ctl,
   output logic [XLEN-1:0]  rdata
);
   localparam logic [XLEN-1:0] FIELD_MASK =
      ((XLEN'(1) << (POS_HI - POS_LO + 1)) - XLEN'(1)) << POS_LO;

   ctl_t             ctl_q, ctl_d;
   logic [EXC_N-1:0] flag_q, flag_d, flag_wr, flag_set;

   assign flag_wr  = sw_wdata[POS_FLAG_LO +: EXC_N];
   assign flag_set = set_vld ? set_exc : '0;

   always_comb begin
      ctl_d = ctl_q;
      if (sw_we) begin
         ctl_d.uf_dis  = sw_wdata[POS_UF_DIS];
         ctl_d.uf_zero = sw_wdata[POS_UF_ZERO];
         ctl_d.rm      = rmode_e'(sw_wdata[POS_RM_LO +: 2]);
         ctl_d.ovf_dis = sw_wdata[POS_OVF_DIS];
         ctl_d.dz_dis  = sw_wdata[POS_DZ_DIS];
         ctl_d.inv_dis = sw_wdata[POS_INV_DIS];
      end
   end

   generate
      if (HW_SET_WINS) begin : g_hw_wins
         assign flag_d = (sw_we ? flag_wr : flag_q) | flag_set;
      end else begin : g_sw_wins
         assign flag_d = sw_we ? flag_wr : (flag_q | flag_set);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         flag_q <= '0;
      end else begin
         ctl_q  <= ctl_d;
         flag_q <= flag_d;
      end
   end

   always_comb begin
      rdata                             = '0;
      rdata[POS_UF_DIS]                 = ctl_q.uf_dis;
      rdata[POS_UF_ZERO]                = ctl_q.uf_zero;
      rdata[POS_RM_LO +: 2]             = ctl_q.rm;
      rdata[POS_FLAG_LO +: EXC_N]       = flag_q;
      rdata[POS_OVF_DIS]                = ctl_q.ovf_dis;
      rdata[POS_DZ_DIS]                 = ctl_q.dz_dis;
      rdata[POS_INV_DIS]                = ctl_q.inv_dis;
   end

   assign ctl = ctl_q;

   logic unused_wdata;
   generate
      if (XLEN > POS_HI + 1) begin : g_upper
         assign unused_wdata = ^{sw_wdata[XLEN-1:POS_HI+1], sw_wdata[POS_LO-1:0]};
      end else begin : g_no_upper
         assign unused_wdata = ^sw_wdata[POS_LO-1:0];
      end
   endgenerate

   // Padding bits never carry data (R2)
   assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~FIELD_MASK) == '0)
      else $error("padding bit set");

   generate
      for (genvar k = 0; k < EXC_N; k++) begin : g_flag_chk
         assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[k] && !sw_we) |=> flag_q[k])
            else $error("sticky flag dropped");
         if (HW_SET_WINS) begin : g_win
            assert_hw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
               (set_vld && set_exc[k]) |=> flag_q[k])
               else $error("hardware set lost");
         end
      end
   endgenerate
endmodule

// File: rtl/fpx_rnd_sel.sv
module fpx_rnd_sel
   import fpx_pkg::*;
(
   input  logic       use_dyn,
   input  rmode_e     dyn_rm,
   input  logic [1:0] instr_rm,
   output logic [1:0] rm_out
);
   always_comb begin
      if (use_dyn) rm_out = dyn_rm;
      else         rm_out = instr_rm;
   end
endmodule

// File: rtl/fpx_trap_dec.sv
module fpx_trap_dec
   import fpx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic [EXC_N-1:0] exc,
   input  logic             inv_fix,
   input  ctl_t             ctl,
   output logic             trap,
   output logic [EXC_N-1:0] cause,
   output logic             use_ieee,
   output logic             use_zero
);
   logic [EXC_N-1:0] hit;
   logic [EXC_N-1:0] quiet;
   logic             unused_bits;

   assign hit = vld ? exc : '0;
   assign unused_bits = ^{ctl.rm};

   always_comb begin
      quiet          = '0;
      quiet[EXC_INV] = ctl.inv_dis && inv_fix;
      quiet[EXC_DZE] = ctl.dz_dis;
      quiet[EXC_OVF] = ctl.ovf_dis;
      quiet[EXC_UNF] = ctl.uf_dis && ctl.uf_zero;
      quiet[EXC_INE] = 1'b1;
      quiet[EXC_IOV] = 1'b0;
   end

   assign cause    = hit & ~quiet;
   assign trap     = |cause;
   assign use_ieee = (hit[EXC_INV] & quiet[EXC_INV]) |
                     (hit[EXC_DZE] & quiet[EXC_DZE]) |
                     (hit[EXC_OVF] & quiet[EXC_OVF]);
   assign use_zero = hit[EXC_UNF] & quiet[EXC_UNF];

   assert_ine_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cause[EXC_INE])
      else $error("inexact raised a trap");

   assert_uf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      use_zero |-> (exc[EXC_UNF] && !cause[EXC_UNF] && ctl.uf_dis))
      else $error("zero forced while underflow trapped");

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |-> (!trap && !use_ieee && !use_zero))
      else $error("decision without completion");

   assert_iov_traps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && exc[EXC_IOV]) |-> trap)
      else $error("integer overflow did not trap");
endmodule

// File: rtl/fpx_ctl.sv
module fpx_ctl
   import fpx_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter bit TRAP_REG    = 1'b0,
   parameter bit HW_SET_WINS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_we,
   input  logic [XLEN-1:0] sw_wdata,
   output logic [XLEN-1:0] sw_rdata,
   input  logic            cmp_vld,
   input  logic [5:0]      cmp_exc,
   input  logic            cmp_inv_fixable,
   input  logic            cmp_rm_dyn,
   input  logic [1:0]      cmp_rm_static,
   output logic [1:0]      rm_eff,
   output logic            trap_req,
   output logic [5:0]      trap_cause,
   output logic            sub_ieee,
   output logic            sub_zero
);
   generate
      if (XLEN < POS_HI + 1) begin : g_bad_xlen
         $error("XLEN must hold bit 61");
      end
      if (EXC_N != 6) begin : g_bad_exc
         $error("condition vector must be six bits");
      end
   endgenerate

   ctl_t             ctl;
   logic             d_trap, d_ieee, d_zero;
   logic [EXC_N-1:0] d_cause;

   fpx_csr #(.XLEN(XLEN), .HW_SET_WINS(HW_SET_WINS)) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (sw_we),
      .sw_wdata (sw_wdata),
      .set_vld  (cmp_vld),
      .set_exc  (cmp_exc),
      .ctl      (ctl),
      .rdata    (sw_rdata)
   );

   fpx_rnd_sel u_rnd (
      .use_dyn  (cmp_rm_dyn),
      .dyn_rm   (ctl.rm),
      .instr_rm (cmp_rm_static),
      .rm_out   (rm_eff)
   );

   fpx_trap_dec u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (cmp_vld),
      .exc      (cmp_exc),
      .inv_fix  (cmp_inv_fixable),
      .ctl      (ctl),
      .trap     (d_trap),
      .cause    (d_cause),
      .use_ieee (d_ieee),
      .use_zero (d_zero)
   );

   generate
      if (TRAP_REG) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               trap_req   <= 1'b0;
               trap_cause <= '0;
               sub_ieee   <= 1'b0;
               sub_zero   <= 1'b0;
            end else begin
               trap_req   <= d_trap;
               trap_cause <= d_cause;
               sub_ieee   <= d_ieee;
               sub_zero   <= d_zero;
            end
         end
         assert_out_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_vld && cmp_exc[EXC_IOV]) |=> trap_req)
            else $error("registered trap missing");
      end else begin : g_comb_out
         assign trap_req   = d_trap;
         assign trap_cause = d_cause;
         assign sub_ieee   = d_ieee;
         assign sub_zero   = d_zero;
      end
   endgenerate

   assert_req_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req == (trap_cause != '0))
      else $error("trap request disagrees with cause");
endmodule

// File: tb/fpx_ctl_tb.sv
module fpx_ctl_tb;
   localparam logic [63:0] MASK = 64'h3FFE_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_we = 1'b0;
   logic [63:0] sw_wdata = '0;
   logic [63:0] sw_rdata;
   logic        cmp_vld = 1'b0;
   logic [5:0]  cmp_exc = '0;
   logic        cmp_inv_fixable = 1'b0;
   logic        cmp_rm_dyn = 1'b0;
   logic [1:0]  cmp_rm_static = '0;
   logic [1:0]  rm_eff;
   logic        trap_req;
   logic [5:0]  trap_cause;
   logic        sub_ieee;
   logic        sub_zero;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [63:0] shadow = '0;

   always #5 clk = ~clk;

   fpx_ctl #(.XLEN(64), .TRAP_REG(1'b1), .HW_SET_WINS(1'b1)) u_dut (
      .clk, .rst_n, .sw_we, .sw_wdata, .sw_rdata, .cmp_vld, .cmp_exc,
      .cmp_inv_fixable, .cmp_rm_dyn, .cmp_rm_static, .rm_eff,
      .trap_req, .trap_cause, .sub_ieee, .sub_zero
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // expected decision {trap, cause[5:0], ieee, zero} from the requirements
   function automatic logic [8:0] model(logic [63:0] r, logic [5:0] e, logic fx);
      logic [5:0] c;
      logic ie, zr;
      c[0] = e[0] & ~(r[49] & fx);
      c[1] = e[1] & ~r[50];
      c[2] = e[2] & ~r[51];
      c[3] = e[3] & ~(r[61] & r[60]);
      c[4] = 1'b0;
      c[5] = e[5];
      ie = (e[0] & r[49] & fx) | (e[1] & r[50]) | (e[2] & r[51]);
      zr = e[3] & r[61] & r[60];
      return {|c, c, ie, zr};
   endfunction

   task automatic wr(input logic [63:0] d);
      @(negedge clk);
      sw_we = 1'b1; sw_wdata = d;
      @(negedge clk);
      sw_we = 1'b0;
      shadow = d & MASK;
      chk("R2 readback", sw_rdata, shadow);
   endtask

   task automatic complete(input string req, input logic [5:0] e, input logic fx);
      logic [8:0] exp;
      @(negedge clk);
      cmp_vld = 1'b1; cmp_exc = e; cmp_inv_fixable = fx;
      exp = model(shadow, e, fx);
      @(negedge clk);
      cmp_vld = 1'b0; cmp_exc = '0; cmp_inv_fixable = 1'b0;
      chk(req, {55'd0, trap_req, trap_cause, sub_ieee, sub_zero}, {55'd0, exp});
      shadow[57:52] = shadow[57:52] | e;
      chk("R3 flags", sw_rdata, shadow);
   endtask

   task automatic t_reset;
      chk("R1 rdata", sw_rdata, 64'd0);
      chk("R1 outs", {trap_req, trap_cause, sub_ieee, sub_zero}, 64'd0);
   endtask

   task automatic t_rw;
      wr('1);
      chk("R2 all ones", sw_rdata, MASK);
      wr(64'hC001_FFFF_FFFF_FFFF);
      wr('0);
   endtask

   task automatic t_sticky;
      complete("R3 set", 6'b010001, 1'b0);
      complete("R3 none", 6'b000000, 1'b0);
      chk("R3 held", sw_rdata[57:52], 64'h11);
      wr('0);
   endtask

   task automatic t_hw_wins;
      complete("R4 prep", 6'b001000, 1'b0);
      @(negedge clk);
      sw_we = 1'b1; sw_wdata = '0; cmp_vld = 1'b1; cmp_exc = 6'b000100;
      @(negedge clk);
      sw_we = 1'b0; cmp_vld = 1'b0; cmp_exc = '0;
      shadow = 64'd1 << 54;
      chk("R4 hw wins", sw_rdata, shadow);
      wr('0);
   endtask

   task automatic t_round;
      for (int m = 0; m < 4; m++) begin
         wr(64'(m) << 58);
         @(negedge clk);
         cmp_rm_dyn = 1'b1; cmp_rm_static = 2'(3 - m);
         #1 chk("R5 dynamic", 64'(rm_eff), 64'(m));
         cmp_rm_dyn = 1'b0;
         #1 chk("R5 static", 64'(rm_eff), 64'(3 - m));
      end
      wr('0);
   endtask

   task automatic t_underflow;
      wr('0);                complete("R6 uf trap 00", 6'b001000, 1'b0);
      wr(64'd1 << 60);       complete("R6 uf trap 01", 6'b001000, 1'b0);
      wr(64'd1 << 61);       complete("R6 uf trap 10", 6'b001000, 1'b0);
      wr(64'd3 << 60);       complete("R6 uf zero 11", 6'b001000, 1'b0);
      wr('0);
   endtask

   task automatic t_ovf_dz;
      complete("R7 ovf trap", 6'b000100, 1'b0);
      complete("R7 dz trap", 6'b000010, 1'b0);
      wr(64'd1 << 51); complete("R7 ovf quiet", 6'b000100, 1'b0);
      wr(64'd1 << 50); complete("R7 dz quiet", 6'b000010, 1'b0);
      wr('0);
   endtask

   task automatic t_invalid;
      complete("R8 inv trap", 6'b000001, 1'b1);
      wr(64'd1 << 49);
      complete("R8 inv unfixable", 6'b000001, 1'b0);
      complete("R8 inv quiet", 6'b000001, 1'b1);
      wr('0);
   endtask

   task automatic t_ine_iov;
      complete("R9 inexact", 6'b010000, 1'b0);
      wr(64'h3FFE_0000_0000_0000);
      complete("R9 iov", 6'b100000, 1'b0);
      wr('0);
   endtask

   task automatic t_multi;
      wr((64'd1 << 51) | (64'd3 << 60));
      complete("R10 mixed", 6'b111111, 1'b0);
      wr('0);
      complete("R10 all trap", 6'b101111, 1'b1);
      wr('0);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      sw_we = 1'b1; sw_wdata = 64'd1 << 51; cmp_vld = 1'b1; cmp_exc = 6'b000100;
      @(negedge clk);
      sw_we = 1'b0; cmp_vld = 1'b0; cmp_exc = '0;
      chk("R11 old ctl traps", {trap_req, trap_cause}, 64'b1_000100);
      shadow = (64'd1 << 51) | (64'd1 << 54);
      chk("R11 new word", sw_rdata, shadow);
      @(negedge clk);
      chk("R11 one cycle", 64'(trap_req), 64'd0);
      wr('0);
   endtask

   task automatic t_idle;
      @(negedge clk);
      cmp_vld = 1'b0; cmp_exc = 6'b111111;
      @(negedge clk);
      chk("R12 no outs", {trap_req, trap_cause, sub_ieee, sub_zero}, 64'd0);
      cmp_exc = '0;
      chk("R12 no flags", sw_rdata, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_rw;
      t_sticky;
      t_hw_wins;
      t_round;
      t_underflow;
      t_ovf_dz;
      t_invalid;
      t_ine_iov;
      t_multi;
      t_same_cycle;
      t_idle;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule